// File: doc/BRIEF.md
# Addressed Serial Volume Control Interface

This block takes 16-bit command words from a three-wire serial port: a data line, a shift clock and a latch enable. Each word names a target device with two address bits. Up to four devices can share one bus, because each device compares those bits with its own two strap inputs. A word that reaches this device can carry one of four channel steers: left, right, both, or none. It also carries an 8-bit attenuation code.

For each stereo channel, the block holds a registered attenuation setting in 1 dB steps and a mute flag. An analog attenuator downstream would use these values.

The three serial lines are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and the block detects edges from the synchronised samples. Nothing here carries streaming data. All ports are plain control and status pins with no handshake. The reset input is active low.

Top module: `vol_ctrl_top`

## Requirements
- R1: While reset is low, and after it is released, both channels report mute = 1 and attenuation = 80, until a valid word changes them.
- R2: Each rising edge of the serial clock shifts the data line into a 16-bit word, with the first bit sent landing in bit 15. When more than 16 bits arrive before a latch, the 16 most recent bits form the word.
- R3: Settings change only on a rising edge of the latch line. A latch rise first seen at system clock edge k, through the two-stage synchroniser, updates the outputs at edge k+2. At all other times the outputs hold.
- R4: A latch rise is ignored when fewer than 16 serial clock rises have occurred since the previous latch rise. Every latch rise, accepted or not, restarts the bit count.
- R5: A word is applied only when bit 13 equals strap_a and bit 12 equals strap_b. Otherwise both channels keep their settings.
- R6: Bits 9:8 pick the target: 00 writes both channels, 01 writes left only, 10 writes right only, 11 writes neither.
- R7: An attenuation code (bits 7:0) from 0x00 to 0x50 sets that channel's attenuation to the code value in dB and clears its mute flag.
- R8: A code from 0x51 to 0xFF sets that channel's mute flag and reports attenuation 80.
- R9: Bits 15, 14, 11 and 10 have no effect on the result.
- R10: When a serial clock rise and a latch rise are seen in the same system clock cycle, the bit shifted by that clock rise counts as part of the word being latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_dat | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock; data is taken on its rising edge |
| ser_lat | input | 1 | Latch enable; its rising edge applies the word |
| strap_a | input | 1 | Device address strap, compared with word bit 13 |
| strap_b | input | 1 | Device address strap, compared with word bit 12 |
| left_att | output | 7 | Left channel attenuation in dB (0 to 80) |
| left_mute | output | 1 | Left channel mute flag |
| right_att | output | 7 | Right channel attenuation in dB (0 to 80) |
| right_mute | output | 1 | Right channel mute flag |

## Verification
Shifting a bit and accepting a latch can both happen in the same system clock cycle. The bench provokes this by raising the serial clock and the latch line in the same cycle, with the 16th bit on the data line. The result counts as correct only if the word is accepted, with the final bit included in the address, steering and code fields. A behavioural model predicts the outputs on every clock, including the exact cycle of the update, so a shift that lands one cycle late, or is left out of the bit count, shows up as a miscompare.

// File: rtl/volctl_pkg.sv
package volctl_pkg;
  localparam int FRAME_W  = 16;
  localparam int CODE_W   = 8;
  localparam int MAX_STEP = 80;
  localparam int ATT_W    = $clog2(MAX_STEP + 1);
  localparam int N_CHAN   = 2;

  // field positions that a neighbouring bus master encodes
  localparam int ADDR_A_POS = 13;
  localparam int ADDR_B_POS = 12;
  localparam int SEL_HI     = 9;
  localparam int SEL_LO     = 8;

  typedef enum logic [1:0] {
    SEL_BOTH  = 2'b00,
    SEL_LEFT  = 2'b01,
    SEL_RIGHT = 2'b10,
    SEL_NONE  = 2'b11
  } chsel_e;

  typedef struct packed {
    logic             mute;
    logic [ATT_W-1:0] att;
  } chan_st_t;

  localparam chan_st_t CHAN_RESET = '{mute: 1'b1, att: ATT_W'(MAX_STEP)};

  function automatic chan_st_t code_to_state(input logic [CODE_W-1:0] code);
    chan_st_t s;
    s.mute = (code > CODE_W'(MAX_STEP));
    s.att  = s.mute ? ATT_W'(MAX_STEP) : code[ATT_W-1:0];
    return s;
  endfunction
endpackage

// File: rtl/volctl_sync.sv
module volctl_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else if (s == 0) begin
          stage_q[s] <= async_i;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/volctl_shifter.sv
module volctl_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               sdat_s,
  input  logic               slat_s,
  output logic [FRAME_W-1:0] frame_o,
  output logic               take_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic               sclk_q, slat_q;
  logic               rise_clk, rise_lat;
  logic [FRAME_W-1:0] shreg_q, shreg_nx;
  logic [CNT_W-1:0]   cnt_q, cnt_nx;

  always_comb begin
    rise_clk = sclk_s & ~sclk_q;
    rise_lat = slat_s & ~slat_q;
    shreg_nx = rise_clk ? {shreg_q[FRAME_W-2:0], sdat_s} : shreg_q;
    cnt_nx   = (rise_clk && cnt_q != FULL) ? cnt_q + 1'b1 : cnt_q;
    // a shift in the latch cycle belongs to the word being latched
    frame_o  = shreg_nx;
    take_o   = rise_lat && (cnt_nx == FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      slat_q  <= 1'b0;
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      sclk_q  <= sclk_s;
      slat_q  <= slat_s;
      shreg_q <= shreg_nx;
      cnt_q   <= rise_lat ? '0 : cnt_nx;
    end
  end
endmodule

// File: rtl/volctl_chan.sv
module volctl_chan
  import volctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] code_i,
  output chan_st_t          st_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_o <= CHAN_RESET;
    end else if (wr_i) begin
      st_o <= code_to_state(code_i);
    end
  end
endmodule

// File: rtl/vol_ctrl_top.sv
module vol_ctrl_top
  import volctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_dat,
  input  logic             ser_clk,
  input  logic             ser_lat,
  input  logic             strap_a,
  input  logic             strap_b,
  output logic [ATT_W-1:0] left_att,
  output logic             left_mute,
  output logic [ATT_W-1:0] right_att,
  output logic             right_mute
);
  logic [2:0]         raw_lines, sync_lines;
  logic [FRAME_W-1:0] frame;
  logic               take;
  logic               addr_hit;
  chsel_e             sel;
  logic [N_CHAN-1:0]  wr;
  chan_st_t           st [N_CHAN];

  assign raw_lines = {ser_lat, ser_clk, ser_dat};

  volctl_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_lines),
    .sync_o  (sync_lines)
  );

  volctl_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_s  (sync_lines[1]),
    .sdat_s  (sync_lines[0]),
    .slat_s  (sync_lines[2]),
    .frame_o (frame),
    .take_o  (take)
  );

  always_comb begin
    addr_hit = (frame[ADDR_A_POS] == strap_a) && (frame[ADDR_B_POS] == strap_b);
    sel      = chsel_e'(frame[SEL_HI:SEL_LO]);
    wr[0]    = take && addr_hit && (sel == SEL_BOTH || sel == SEL_LEFT);
    wr[1]    = take && addr_hit && (sel == SEL_BOTH || sel == SEL_RIGHT);
  end

  generate
    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
      volctl_chan u_chan (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr[c]),
        .code_i (frame[CODE_W-1:0]),
        .st_o   (st[c])
      );
    end
  endgenerate

  assign left_att   = st[0].att;
  assign left_mute  = st[0].mute;
  assign right_att  = st[1].att;
  assign right_mute = st[1].mute;
endmodule

// File: rtl/vol_ctrl_chk.sv
module vol_ctrl_chk
  import volctl_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               strap_a,
  input logic               strap_b,
  input logic               take,
  input logic [FRAME_W-1:0] frame,
  input logic [ATT_W-1:0]   left_att,
  input logic               left_mute,
  input logic [ATT_W-1:0]   right_att,
  input logic               right_mute
);
  // R1
  reset_mute_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (left_mute && right_mute));

  // R8
  mute_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left_mute |-> left_att == ATT_W'(MAX_STEP)) and
    (right_mute |-> right_att == ATT_W'(MAX_STEP)));

  // R7
  att_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    left_att <= ATT_W'(MAX_STEP) && right_att <= ATT_W'(MAX_STEP));

  // R3
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(take) |-> ($stable(left_att) && $stable(left_mute) &&
                      $stable(right_att) && $stable(right_mute)));

  // R5
  addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (frame[ADDR_A_POS] != strap_a || frame[ADDR_B_POS] != strap_b)) |=>
    ($stable(left_att) && $stable(left_mute) && $stable(right_att) && $stable(right_mute)));

  // R6
  sel_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && frame[SEL_HI:SEL_LO] == 2'b11) |=>
    ($stable(left_att) && $stable(left_mute) && $stable(right_att) && $stable(right_mute)));
endmodule

bind vol_ctrl_top vol_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .strap_a    (strap_a),
  .strap_b    (strap_b),
  .take       (take),
  .frame      (frame),
  .left_att   (left_att),
  .left_mute  (left_mute),
  .right_att  (right_att),
  .right_mute (right_mute)
);

// File: tb/test_vol_ctrl_top.sv
module test_vol_ctrl_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_dat = 1'b0, ser_clk = 1'b0, ser_lat = 1'b0;
  logic strap_a = 1'b1, strap_b = 1'b0;
  logic [6:0] left_att, right_att;
  logic left_mute, right_mute;

  int vectors = 0, miscompares = 0;
  int exp_la = 80, exp_ra = 80;
  bit exp_lm = 1, exp_rm = 1;
  bit q[$];
  string cur_tag = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vol_ctrl_top i_vol_ctrl_top (
    .clk(clk), .rst_n(rst_n), .ser_dat(ser_dat), .ser_clk(ser_clk),
    .ser_lat(ser_lat), .strap_a(strap_a), .strap_b(strap_b),
    .left_att(left_att), .left_mute(left_mute),
    .right_att(right_att), .right_mute(right_mute)
  );

  // cycle-by-cycle comparison against the model (R3 timing covered here)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (left_att != 7'(exp_la) || left_mute != exp_lm ||
          right_att != 7'(exp_ra) || right_mute != exp_rm) begin
        miscompares++;
        $display("FAIL %s R3 t=%0t: act L=%0d/%0b R=%0d/%0b exp L=%0d/%0b R=%0d/%0b",
                 cur_tag, $time, left_att, left_mute, right_att, right_mute,
                 exp_la, exp_lm, exp_ra, exp_rm);
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: act %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // model: apply the latch (R2 R4 R5 R6 R7 R8 R9)
  task automatic model_latch();
    if (q.size() >= 16) begin
      logic [15:0] w;
      for (int i = 0; i < 16; i++) w[15-i] = q[q.size()-16+i];
      if (w[13] == strap_a && w[12] == strap_b) begin
        int code = int'(w[7:0]);
        bit m = code > 80;
        int a = m ? 80 : code;
        if (w[9:8] == 2'b00 || w[9:8] == 2'b01) begin exp_la = a; exp_lm = m; end
        if (w[9:8] == 2'b00 || w[9:8] == 2'b10) begin exp_ra = a; exp_rm = m; end
      end
    end
    q.delete();
  endtask

  task automatic do_latch(bit with_clk, bit b);
    @(negedge clk);
    if (with_clk) begin ser_dat = b; end
    ser_lat = 1'b1;
    if (with_clk) begin ser_clk = 1'b1; q.push_back(b); end
    repeat (3) @(posedge clk);
    #1 model_latch();
    tick(2);
    ser_lat = 1'b0;
    ser_clk = 1'b0;
    tick(4);
  endtask

  task automatic send_bit(bit b);
    @(negedge clk);
    ser_dat = b;
    tick(3);
    ser_clk = 1'b1;
    q.push_back(b);
    tick(3);
    ser_clk = 1'b0;
  endtask

  task automatic send_bits(logic [31:0] v, int n);
    for (int i = n-1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic frame(logic [15:0] w);
    send_bits(32'(w), 16);
    do_latch(1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    tick(3);
    check("R1 left_mute in reset", int'(left_mute), 1);
    check("R1 right_att in reset", int'(right_att), 80);
    rst_n = 1'b1;
    tick(3);
    check("R1 left_att after reset", int'(left_att), 80);
    check("R1 right_mute after reset", int'(right_mute), 1);

    cur_tag = "R2 R7"; frame(16'h2014);
    check("R7 left_att code 0x14", int'(left_att), 20);
    check("R7 right_mute cleared", int'(right_mute), 0);

    cur_tag = "R6 left"; frame(16'h2105);
    check("R6 left only", int'(left_att), 5);
    check("R6 right untouched", int'(right_att), 20);

    cur_tag = "R6 right R7"; frame(16'h2250);
    check("R7 code 0x50 right", int'(right_att), 80);
    check("R7 code 0x50 unmuted", int'(right_mute), 0);

    cur_tag = "R6 none"; frame(16'h2300);
    check("R6 sel 11 left", int'(left_att), 5);
    check("R6 sel 11 right", int'(right_att), 80);

    cur_tag = "R5 miss"; frame(16'h1001);
    check("R5 addr mismatch left", int'(left_att), 5);
    check("R5 addr mismatch right mute", int'(right_mute), 0);

    cur_tag = "R8"; frame(16'h2051);
    check("R8 code 0x51 mute", int'(left_mute), 1);
    check("R8 code 0x51 att", int'(right_att), 80);
    frame(16'h2002); frame(16'h20FF);
    check("R8 code 0xFF mute", int'(right_mute), 1);

    cur_tag = "R9"; frame(16'hEC03);
    check("R9 ignored bits left", int'(left_att), 3);
    check("R9 ignored bits right", int'(right_att), 3);

    cur_tag = "R4 short"; send_bits(32'h0000_2107, 10); do_latch(1'b0, 1'b0);
    check("R4 short word ignored", int'(left_att), 3);
    frame(16'h2107);
    check("R4 count restarted", int'(left_att), 7);

    cur_tag = "R2 long"; send_bits(32'h000F_2209, 20); do_latch(1'b0, 1'b0);
    check("R2 last 16 bits kept", int'(right_att), 9);
    check("R2 left untouched", int'(left_att), 7);

    cur_tag = "R10"; send_bits(32'h0000_1005, 15); do_latch(1'b1, 1'b0);
    check("R10 same-cycle shift left", int'(left_att), 10);
    check("R10 same-cycle shift right", int'(right_att), 10);

    cur_tag = "R5 straps";
    @(negedge clk); strap_a = 1'b0; strap_b = 1'b1;
    frame(16'h100C);
    check("R5 new strap match", int'(left_att), 12);
    frame(16'h2001);
    check("R5 old address rejected", int'(right_att), 12);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule